// File: doc/BRIEF.md
# Extended-Register Subtract Execute Unit

This block is a one-instruction execute stage that owns its own architectural state: thirty-one 64-bit general registers and a separate stack pointer. Each cycle it may accept a 32-bit instruction word with a valid strobe. It decodes the subtract-with-extended-register encoding and reads the two source operands. It then takes a byte, halfword, word or doubleword slice of the second operand, extends it with zeros or with its sign bit, and shifts it left by 0 to 4 places. It subtracts that value from the first operand and writes the difference back on the next clock edge. The latency is the same for every operand value.

Words that do not carry the expected fixed bits, and words whose shift field exceeds 4, raise a one-cycle undefined flag and change no state. A debug port reads any register or the stack pointer combinationally and can also load them. Without a load path the state could never leave its reset value of zero. When an instruction and a debug load target the same register on the same edge, the instruction's result is kept.

Top module: `subx_exec_unit`

## Requirements
- R1: A valid word is accepted only when bits 30:21 equal 1001011001. Any other valid word raises `undef_pulse` and leaves every register and the stack pointer unchanged.
- R2: An accepted-pattern word whose shift field (bits 12:10) is 5, 6 or 7 raises `undef_pulse` and writes nothing.
- R3: Bit 31 selects the width: 0 gives a 32-bit operation, whose result is zero-extended to 64 bits when it is written, and 1 gives a 64-bit operation.
- R4: Bits 15:13 select the extension. Bit 15 set means sign extension and clear means zero extension. Bits 14:13 select the slice width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. A slice at least as wide as the datasize passes the operand through unchanged.
- R5: The extended second operand is shifted left by the value in bits 12:10, in the range 0 to 4, before the subtraction.
- R6: A first-source index (bits 9:5) of 31 reads the stack pointer, and a destination index (bits 4:0) of 31 writes the stack pointer.
- R7: A second-source index (bits 20:16) of 31 reads as zero, never as the stack pointer.
- R8: The written value equals first operand minus second operand modulo 2^datasize. It is visible on the debug read port right after the clock edge that samples the valid word.
- R9: `undef_pulse` is high for exactly the cycle after each rejected valid word and is low otherwise.
- R10: While `rst_n` is low at a clock edge, all registers and the stack pointer clear to zero and `undef_pulse` goes low.
- R11: `dbg_idx` 0 to 30 selects a general register and 31 selects the stack pointer, both for reads and for loads made with `dbg_we`. If an executing instruction writes the same target on the same edge, the instruction's result wins; loads to other targets still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_idx | input | 5 | Debug register select (31 = stack pointer) |
| dbg_we | input | 1 | Debug load enable |
| dbg_wdata | input | 64 | Debug load value |
| dbg_rdata | output | 64 | Debug read value of the selected register |
| undef_pulse | output | 1 | One-cycle flag for a rejected instruction |

## Verification
The bench makes an instruction write-back and a debug load reach the register file on the same edge. It drives `dbg_we` in the same cycle as `instr_valid`, once with both aimed at the same register and once at different registers. After the edge it reads both targets back. The shared target must hold the subtraction result, and the other target must hold the loaded value. Around this, a sweep over both widths, all eight extension codes, every legal shift and several operand patterns compares each result with a difference computed arithmetically in the bench.

// File: rtl/subx_pkg.sv
// Package: shared widths and the decoded-instruction record.
// Assumes a fixed 64-bit register width and 5-bit register indices.
package subx_pkg;
    localparam int XLEN     = 64;
    localparam int IDXW     = 5;
    localparam int NGPR     = 31;
    localparam int WORDW    = 32;
    localparam int SHW      = 3;
    localparam int MAXSHIFT = 4;

    typedef enum logic [1:0] {
        SLICE_B = 2'b00,
        SLICE_H = 2'b01,
        SLICE_W = 2'b10,
        SLICE_X = 2'b11
    } slice_e;

    typedef struct packed {
        logic            legal;
        logic            wide;
        logic            signx;
        slice_e          slice;
        logic [SHW-1:0]  amt;
        logic [IDXW-1:0] rm;
        logic [IDXW-1:0] rn;
        logic [IDXW-1:0] rd;
    } subx_dec_t;
endpackage

// File: rtl/subx_decode.sv
// Module: subx_decode
// Splits an instruction word into fields and judges whether it is a legal
// extended-register subtract. Purely combinational; assumes the caller
// qualifies the result with its own valid strobe.
module subx_decode
    import subx_pkg::*;
#(
    parameter logic [9:0] FIXED_BITS = 10'b1001011001
) (
    input  logic [WORDW-1:0] word,
    output subx_dec_t        dec
);
    logic pattern_ok;
    logic shift_ok;

    // Field extraction and legality check.
    always_comb begin
        pattern_ok = (word[30:21] == FIXED_BITS);
        shift_ok   = (word[12:10] <= SHW'(MAXSHIFT));
        dec.legal  = pattern_ok && shift_ok;
        dec.wide   = word[31];
        dec.signx  = word[15];
        dec.slice  = slice_e'(word[14:13]);
        dec.amt    = word[12:10];
        dec.rm     = word[20:16];
        dec.rn     = word[9:5];
        dec.rd     = word[4:0];
    end
endmodule

// File: rtl/subx_opnd_ext.sv
// Module: subx_opnd_ext
// Builds the second operand: slices the source, extends it with zeros or
// its sign bit, shifts it left, and clips it to the datasize. Assumes the
// shift amount has already been checked against the legal range.
module subx_opnd_ext
    import subx_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  subx_dec_t       dec,
    output logic [XLEN-1:0] opnd
);
    localparam int HALFX = XLEN / 2;

    logic [XLEN-1:0] src_dw;
    logic [XLEN-1:0] ext_v;
    logic [XLEN-1:0] shf_v;

    // Narrow source for 32-bit operations.
    always_comb begin
        src_dw = dec.wide ? src : {{HALFX{1'b0}}, src[HALFX-1:0]};
    end

    // Slice selection and extension.
    always_comb begin
        unique case (dec.slice)
            SLICE_B: ext_v = {{(XLEN-8){dec.signx & src_dw[7]}},   src_dw[7:0]};
            SLICE_H: ext_v = {{(XLEN-16){dec.signx & src_dw[15]}}, src_dw[15:0]};
            SLICE_W: ext_v = {{(XLEN-32){dec.signx & src_dw[31]}}, src_dw[31:0]};
            default: ext_v = src_dw;
        endcase
    end

    // Left shift and clip to datasize.
    always_comb begin
        shf_v = ext_v << dec.amt;
        opnd  = dec.wide ? shf_v : {{HALFX{1'b0}}, shf_v[HALFX-1:0]};
    end
endmodule

// File: rtl/subx_regfile.sv
// Module: subx_regfile
// General registers plus stack pointer. Port A treats index 31 as the
// stack pointer, port B treats it as zero, the debug port as the stack
// pointer. Execute writes take priority over debug loads to one target.
module subx_regfile
    import subx_pkg::*;
#(
    parameter int NREG = NGPR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_we,
    input  logic [IDXW-1:0] ex_idx,
    input  logic [XLEN-1:0] ex_data,
    input  logic            dbg_we,
    input  logic [IDXW-1:0] dbg_idx,
    input  logic [XLEN-1:0] dbg_wdata,
    input  logic [IDXW-1:0] a_idx,
    output logic [XLEN-1:0] a_data,
    input  logic [IDXW-1:0] b_idx,
    output logic [XLEN-1:0] b_data,
    output logic [XLEN-1:0] dbg_rdata
);
    localparam logic [IDXW-1:0] SPECIAL = IDXW'(NREG);

    logic [XLEN-1:0] gpr [NREG];
    logic [XLEN-1:0] sp_q;

    // Register and stack-pointer update with execute priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) gpr[i] <= '0;
            sp_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ex_we && ex_idx == IDXW'(i))
                    gpr[i] <= ex_data;
                else if (dbg_we && dbg_idx == IDXW'(i))
                    gpr[i] <= dbg_wdata;
            end
            if (ex_we && ex_idx == SPECIAL)
                sp_q <= ex_data;
            else if (dbg_we && dbg_idx == SPECIAL)
                sp_q <= dbg_wdata;
        end
    end

    // Combinational read ports.
    always_comb begin
        a_data    = (a_idx == SPECIAL)   ? sp_q : gpr[a_idx];
        b_data    = (b_idx == SPECIAL)   ? '0   : gpr[b_idx];
        dbg_rdata = (dbg_idx == SPECIAL) ? sp_q : gpr[dbg_idx];
    end

    AST_SP_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_we && ex_idx == SPECIAL |=> sp_q == $past(ex_data)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> sp_q == '0); // R10

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_GPR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
            ex_we && ex_idx == IDXW'(g) |=> gpr[g] == $past(ex_data)); // R11
    end
endmodule

// File: rtl/subx_exec_unit.sv
// Module: subx_exec_unit
// Top of the extended-register subtract execute stage. Decodes, reads,
// extends and subtracts in one cycle and writes back on the next edge.
// Assumes at most one instruction per cycle; no flags are produced.
module subx_exec_unit
    import subx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [WORDW-1:0] instr_word,
    input  logic [IDXW-1:0]  dbg_idx,
    input  logic             dbg_we,
    input  logic [XLEN-1:0]  dbg_wdata,
    output logic [XLEN-1:0]  dbg_rdata,
    output logic             undef_pulse
);
    localparam int HALFX = XLEN / 2;

    subx_dec_t       dec;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] rm_val;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] diff;
    logic [XLEN-1:0] result;
    logic            fire;
    logic            undef_q;

    subx_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    subx_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_we     (fire),
        .ex_idx    (dec.rd),
        .ex_data   (result),
        .dbg_we    (dbg_we),
        .dbg_idx   (dbg_idx),
        .dbg_wdata (dbg_wdata),
        .a_idx     (dec.rn),
        .a_data    (opa),
        .b_idx     (dec.rm),
        .b_data    (rm_val),
        .dbg_rdata (dbg_rdata)
    );

    subx_opnd_ext u_ext (
        .src  (rm_val),
        .dec  (dec),
        .opnd (opb)
    );

    // Subtract as add of inverted operand with carry-in, clip to datasize.
    always_comb begin
        fire   = instr_valid && dec.legal;
        diff   = opa + ~opb + XLEN'(1);
        result = dec.wide ? diff : {{HALFX{1'b0}}, diff[HALFX-1:0]};
    end

    // One-cycle undefined flag.
    always_ff @(posedge clk) begin
        if (!rst_n) undef_q <= 1'b0;
        else        undef_q <= instr_valid && !dec.legal;
    end

    assign undef_pulse = undef_q;

    AST_BADWORD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_word[30:21] != 10'b1001011001 |=> undef_pulse); // R1

    AST_SHIFT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_word[12:10] > 3'd4 |=> undef_pulse); // R2

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !undef_pulse); // R9
endmodule

// File: tb/subx_exec_unit_tb.sv
module subx_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [4:0]  dbg_idx = '0;
    logic        dbg_we = 1'b0;
    logic [63:0] dbg_wdata = '0;
    logic [63:0] dbg_rdata;
    logic        undef_pulse;

    int total = 0;
    int bad = 0;
    logic [63:0] mdl [32];

    always #4 clk = ~clk;

    subx_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .dbg_idx(dbg_idx), .dbg_we(dbg_we),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .undef_pulse(undef_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit sf, input logic [4:0] rm,
        input logic [2:0] opt, input logic [2:0] sh, input logic [4:0] rn, input logic [4:0] rd);
        return {sf, 10'b1001011001, rm, opt, sh, rn, rd};
    endfunction

    function automatic logic [63:0] ref_b(input logic [63:0] v, input logic [2:0] opt,
        input logic [2:0] sh, input bit w64);
        logic [63:0] x;
        logic [63:0] mask;
        int bits;
        bits = 8 << opt[1:0];
        x = w64 ? v : (v & 64'hFFFF_FFFF);
        if (bits < 64) begin
            mask = (64'd1 << bits) - 64'd1;
            x = x & mask;
            if (opt[2] && x[bits-1]) x = x | ~mask;
        end
        x = x << sh;
        if (!w64) x = x & 64'hFFFF_FFFF;
        return x;
    endfunction

    task automatic dload(input logic [4:0] idx, input logic [63:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_idx = idx; dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
        mdl[idx] = val;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] idx, input logic [63:0] exp);
        dbg_idx = idx;
        #1;
        chk(req, dbg_rdata, exp);
    endtask

    // Issue one word, check the flag, update the model and check the target.
    task automatic run(input string req, input logic [31:0] w, input bit exp_undef);
        logic [63:0] a, b, r;
        bit w64;
        w64 = w[31];
        a = mdl[w[9:5]];
        b = (w[20:16] == 5'd31) ? 64'd0 : mdl[w[20:16]];
        r = (w64 ? a : (a & 64'hFFFF_FFFF)) - ref_b(b, w[15:13], w[12:10], w64);
        if (!w64) r = r & 64'hFFFF_FFFF;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
        chk({req, " R9 flag"}, {63'd0, undef_pulse}, {63'd0, exp_undef});
        if (!exp_undef) mdl[w[4:0]] = r;
        rd_chk(req, w[4:0], mdl[w[4:0]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] va [3];
        logic [63:0] vb [3];
        va[0] = 64'h0123_4567_89AB_CDEF; vb[0] = 64'h0000_0000_0000_0081;
        va[1] = 64'hFFFF_FFFF_0000_0010; vb[1] = 64'h8000_0000_F7F6_8F80;
        va[2] = 64'h0000_0000_0000_0000; vb[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        for (int i = 0; i < 32; i++) rd_chk("R10 reset", 5'(i), 64'd0);
        chk("R10 flag", {63'd0, undef_pulse}, 64'd0);
        rst_n = 1'b1;
        // R11: debug load/read of a register and SP
        dload(5'd7, 64'hDEAD_BEEF_0000_1111);
        rd_chk("R11 load", 5'd7, 64'hDEAD_BEEF_0000_1111);
        // R3 R4 R5 R8: sweep width x option x shift x data
        for (int sf = 0; sf < 2; sf++)
            for (int opt = 0; opt < 8; opt++)
                for (int sh = 0; sh < 5; sh++)
                    for (int p = 0; p < 3; p++) begin
                        dload(5'd1, va[p]);
                        dload(5'd2, vb[p]);
                        run("R4 R5 R8 R3 sweep", mk(sf[0], 5'd2, 3'(opt), 3'(sh), 5'd1, 5'(3 + p)), 1'b0);
                    end
        // R2: illegal shift writes nothing
        for (int sh = 5; sh < 8; sh++)
            run("R2 shift", mk(1'b1, 5'd2, 3'd3, 3'(sh), 5'd1, 5'd3), 1'b1);
        // R1: every fixed bit flipped
        for (int b = 21; b < 31; b++) begin
            logic [31:0] w;
            w = mk(1'b1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd4);
            w[b] = ~w[b];
            run("R1 pattern", w, 1'b1);
        end
        // R9: flag drops when idle
        @(negedge clk);
        chk("R9 idle", {63'd0, undef_pulse}, 64'd0);
        // R7: Rm=31 is zero
        dload(5'd31, 64'h1000);
        dload(5'd1, 64'h55);
        run("R7 zero src", mk(1'b1, 5'd31, 3'd3, 3'd2, 5'd1, 5'd5), 1'b0);
        rd_chk("R7 value", 5'd5, 64'h55);
        // R6: Rn=31 reads SP, Rd=31 writes SP
        run("R6 sp src", mk(1'b1, 5'd1, 3'd3, 3'd0, 5'd31, 5'd6), 1'b0);
        rd_chk("R6 sp src value", 5'd6, 64'h1000 - 64'h55);
        run("R6 sp dst", mk(1'b0, 5'd1, 3'd3, 3'd4, 5'd31, 5'd31), 1'b0);
        rd_chk("R6 sp dst value", 5'd31, 64'h0000_0000_0000_0AB0);
        // R11: same-edge collision, instruction wins; other target loads
        dload(5'd1, 64'd100);
        dload(5'd2, 64'd1);
        for (int t = 0; t < 2; t++) begin
            logic [4:0] tgt;
            tgt = (t == 0) ? 5'd9 : 5'd10;
            @(negedge clk);
            instr_valid = 1'b1; instr_word = mk(1'b1, 5'd2, 3'd3, 3'd0, 5'd1, 5'd9);
            dbg_we = 1'b1; dbg_idx = tgt; dbg_wdata = 64'h7777;
            @(negedge clk);
            instr_valid = 1'b0; dbg_we = 1'b0;
            rd_chk("R11 collide exec", 5'd9, 64'd99);
            if (t == 1) rd_chk("R11 collide other", 5'd10, 64'h7777);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule